// File: doc/BRIEF.md
# SPI FPGA configuration sequencer

This block is a hardware SPI master that loads a bitstream into an FPGA whose configuration port is a slave SPI interface. After a start pulse it runs a fixed command script. It reads the device identity and checks it against two accepted values. It then reads status once and sends refresh, write-enable and erase commands. It polls the status word until the erase is reported complete or the poll budget runs out.

When the erase has completed, the whole bitstream goes out as one framed write under a single chip-select assertion. The sequencer then sends a write-disable command and a final status read, and decides success from one status bit. Bitstream bytes come from a byte-wide valid/ready source. The source may stall by holding `bs_valid` low, and the block may stall the source by holding `bs_ready` low. A byte is consumed only in a cycle where both are high. While `bs_valid` is high and `bs_ready` is low, the source holds `bs_data` and `bs_last` steady. `bs_last` marks the final payload byte.

The SPI port runs in mode 0 (SCLK idles low, data sampled on the rising edge, shifted on the falling edge), most significant bit first. The SCLK half period is `SCLK_HALF` system clocks. Poll spacing is derived from `CLK_HZ` through a millisecond tick.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `done` and `error` are 0.
- R2: SPI is mode 0, MSB first. SCLK is low whenever chip select is high. MOSI does not change while SCLK is high. Chip select stays high for at least two SCLK periods (4*SCLK_HALF clocks) between frames.
- R3: The first frame is 8 bytes: 0x07 followed by seven 0x00 bytes. The identity is the big-endian word received in bytes 4..7 (byte 4 is the most significant).
- R4: Only identity 0xC2088080 or 0xC2048080 lets the sequence continue. Any other identity ends the run after that frame with `done`=1, `error`=1 and `err_code`=2.
- R5: After a good identity, the block sends an 8-byte status read (0x09 and seven 0x00). It then sends three 4-byte frames in this order: 0x71, 0x4A, 0x70, each followed by three 0x00 bytes.
- R6: Each poll is an 8-byte status read. The erase counts as complete only when the received word equals exactly 0x00010000; any other word, including one with extra bits set, does not count.
- R7: Consecutive polls start at least POLL_MS milliseconds apart, and at most POLL_MAX polls are made. If none matches, the run ends with `err_code`=3 and no bitstream frame is sent.
- R8: The bitstream frame is one chip-select assertion: 0x41, 0xFF, 0xFF, 0xFF, the payload bytes in order, then four 0x00 bytes.
- R9: A payload byte is taken only on `bs_valid` && `bs_ready`. `bs_ready` is high only inside the bitstream frame, and source stalls only stretch the frame.
- R10: After the bitstream frame, the block sends a 4-byte frame 0x4F with three 0x00 bytes, then an 8-byte status read.
- R11: If bit 14 (mask 0x00004000) of the final status word is set, the run ends with `done`=1 and `error`=0. Otherwise it ends with `done`=1, `error`=1 and `err_code`=4.
- R12: If `bs_empty` is high when start is accepted, the run ends one cycle later with `done`=1, `error`=1, `err_code`=1 and no chip-select activity.
- R13: A start pulse while `busy` is high has no effect on the frame sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a configuration run |
| bs_empty | input | 1 | Source has no bitstream (zero length), sampled at start |
| bs_data | input | 8 | Bitstream byte |
| bs_valid | input | 1 | Bitstream byte valid |
| bs_last | input | 1 | Marks the final bitstream byte |
| bs_ready | output | 1 | Sequencer accepts a bitstream byte |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | SPI data to the FPGA |
| spi_miso | input | 1 | SPI data from the FPGA |
| spi_cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished (held until next start) |
| error | output | 1 | The last run failed; cause in err_code |
| err_code | output | 3 | 0 none, 1 empty, 2 unsupported identity, 3 erase timeout, 4 not configured |

## Verification
The assertions assume that `start` is a single-cycle pulse and that the source keeps `bs_data` and `bs_last` steady while it waits for `bs_ready`. They also assume that `bs_last` marks a payload byte that actually arrives. The stimulus drives every input on the falling clock edge. Its feeder advances only after a handshake it saw at the rising edge, and it asserts `bs_last` on exactly the final byte, with or without inserted stalls. The SPI slave model changes MISO only after a falling SCLK. This matches the mode-0 timing that the assertions rely on.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam logic [7:0] OP_ID      = 8'h07;
  localparam logic [7:0] OP_STAT    = 8'h09;
  localparam logic [7:0] OP_ERASE   = 8'h70;
  localparam logic [7:0] OP_REFRESH = 8'h71;
  localparam logic [7:0] OP_WEN     = 8'h4A;
  localparam logic [7:0] OP_WDIS    = 8'h4F;
  localparam logic [7:0] OP_BURST   = 8'h41;
  localparam logic [31:0] ERASED_WORD = 32'h0001_0000;
  localparam logic [31:0] DONE_MASK   = 32'h0000_4000;

  typedef enum logic [2:0] {ERR_NONE, ERR_EMPTY, ERR_UNSUP, ERR_TIMEOUT, ERR_NOTCFG} err_e;
  typedef enum logic [3:0] {ST_ID, ST_STAT0, ST_REF, ST_WEN, ST_ERASE, ST_POLL,
                            ST_BURST, ST_WDIS, ST_STATF} step_e;
  typedef enum logic [2:0] {PH_IDLE, PH_GAP, PH_LOAD, PH_BYTE, PH_EVAL, PH_WAIT} phase_e;
  typedef enum logic [1:0] {BS_HDR, BS_PAY, BS_TRL} bsub_e;
endpackage

// File: rtl/cfg_ms_tick.sv
module cfg_ms_tick #(
  parameter int CYC = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int W = $clog2(CYC + 1);
  logic [W-1:0] cnt;

  assign tick = (cnt == W'(CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfg_spi_byte.sv
module cfg_spi_byte #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       fin,
  output logic       active
);
  localparam int CW = $clog2(HALF + 1);
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; bitn <= '0; sh <= '0; rx <= '0;
      sclk <= 1'b0; fin <= 1'b0; active <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1; sh <= tx; cnt <= '0; bitn <= '0; sclk <= 1'b0;
        end
      end else if (cnt == CW'(HALF - 1)) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            fin    <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int          CLK_HZ    = 100_000_000,
  parameter int          SCLK_HALF = 2,
  parameter int          POLL_MS   = 10,
  parameter int          POLL_MAX  = 500,
  parameter logic [31:0] ID_A      = 32'hC208_8080,
  parameter logic [31:0] ID_B      = 32'hC204_8080
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bs_empty,
  input  logic [7:0] bs_data,
  input  logic       bs_valid,
  input  logic       bs_last,
  output logic       bs_ready,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic [2:0] err_code
);
  localparam int CYC_MS   = CLK_HZ / 1000;
  localparam int GAP_CLKS = 4 * SCLK_HALF;
  localparam int GW       = $clog2(GAP_CLKS + 1);
  localparam int PW       = $clog2(POLL_MAX + 1);
  localparam int MW       = $clog2(POLL_MS + 1);

  step_e  step;
  phase_e ph;
  bsub_e  bsub;
  err_e   err_q;
  logic [2:0]    bidx;
  logic [31:0]   word;
  logic          last_q;
  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] poll_cnt;
  logic [MW-1:0] ms_cnt;
  logic          go, fin, eng_active, tick;
  logic [7:0]    tx, rx;

  function automatic logic [7:0] step_op(step_e s);
    case (s)
      ST_ID:    return OP_ID;
      ST_REF:   return OP_REFRESH;
      ST_WEN:   return OP_WEN;
      ST_ERASE: return OP_ERASE;
      ST_WDIS:  return OP_WDIS;
      default:  return OP_STAT;
    endcase
  endfunction

  function automatic logic step_rd(step_e s);
    return (s == ST_ID) || (s == ST_STAT0) || (s == ST_POLL) || (s == ST_STATF);
  endfunction

  assign err_code = err_q;

  cfg_spi_byte #(.HALF(SCLK_HALF)) u_byte (
    .clk(clk), .rst_n(rst_n), .go(go), .tx(tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx(rx), .fin(fin), .active(eng_active));

  cfg_ms_tick #(.CYC(CYC_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(ph == PH_EVAL), .tick(tick));

  // byte selection for the current frame position
  always_comb begin
    go = 1'b0; tx = 8'h00; bs_ready = 1'b0;
    if (ph == PH_LOAD) begin
      if (step == ST_BURST) begin
        case (bsub)
          BS_HDR: begin tx = (bidx == 3'd0) ? OP_BURST : 8'hFF; go = 1'b1; end
          BS_PAY: begin bs_ready = 1'b1; tx = bs_data; go = bs_valid; end
          default: begin tx = 8'h00; go = 1'b1; end
        endcase
      end else begin
        tx = (bidx == 3'd0) ? step_op(step) : 8'h00;
        go = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= ST_ID; ph <= PH_IDLE; bsub <= BS_HDR; err_q <= ERR_NONE;
      bidx <= '0; word <= '0; last_q <= 1'b0; gap_cnt <= '0;
      poll_cnt <= '0; ms_cnt <= '0;
      spi_cs_n <= 1'b1; busy <= 1'b0; done <= 1'b0; error <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          done <= 1'b0; error <= 1'b0; err_q <= ERR_NONE;
          if (bs_empty) begin
            done <= 1'b1; error <= 1'b1; err_q <= ERR_EMPTY;
          end else begin
            busy <= 1'b1; step <= ST_ID; ph <= PH_GAP; gap_cnt <= '0;
          end
        end
        PH_GAP: begin
          if (gap_cnt == GW'(GAP_CLKS - 1)) begin
            gap_cnt <= '0; spi_cs_n <= 1'b0; bidx <= '0; bsub <= BS_HDR;
            ph <= PH_LOAD;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        PH_LOAD: if (go) begin
          ph <= PH_BYTE;
          if (step == ST_BURST && bsub == BS_PAY) last_q <= bs_last;
        end
        PH_BYTE: if (fin) begin
          ph <= PH_LOAD;
          if (step_rd(step) && bidx[2]) word <= {word[23:0], rx};
          if (step == ST_BURST) begin
            case (bsub)
              BS_HDR: if (bidx == 3'd3) bsub <= BS_PAY; else bidx <= bidx + 1'b1;
              BS_PAY: if (last_q) begin bsub <= BS_TRL; bidx <= '0; end
              default: if (bidx == 3'd3) begin spi_cs_n <= 1'b1; ph <= PH_EVAL; end
                       else bidx <= bidx + 1'b1;
            endcase
          end else if (bidx == (step_rd(step) ? 3'd7 : 3'd3)) begin
            spi_cs_n <= 1'b1; ph <= PH_EVAL;
          end else begin
            bidx <= bidx + 1'b1;
          end
        end
        PH_EVAL: begin
          ph <= PH_GAP;
          case (step)
            ST_ID: if (word == ID_A || word == ID_B) step <= ST_STAT0;
                   else begin ph <= PH_IDLE; busy <= 1'b0; done <= 1'b1;
                              error <= 1'b1; err_q <= ERR_UNSUP; end
            ST_STAT0: step <= ST_REF;
            ST_REF:   step <= ST_WEN;
            ST_WEN:   step <= ST_ERASE;
            ST_ERASE: begin step <= ST_POLL; poll_cnt <= '0; end
            ST_POLL:
              if (word == ERASED_WORD) step <= ST_BURST;
              else if (poll_cnt == PW'(POLL_MAX - 1)) begin
                ph <= PH_IDLE; busy <= 1'b0; done <= 1'b1;
                error <= 1'b1; err_q <= ERR_TIMEOUT;
              end else begin
                poll_cnt <= poll_cnt + 1'b1; ms_cnt <= '0; ph <= PH_WAIT;
              end
            ST_BURST: step <= ST_WDIS;
            ST_WDIS:  step <= ST_STATF;
            default: begin
              ph <= PH_IDLE; busy <= 1'b0; done <= 1'b1;
              if ((word & DONE_MASK) == '0) begin
                error <= 1'b1; err_q <= ERR_NOTCFG;
              end
            end
          endcase
        end
        PH_WAIT: if (tick) begin
          if (ms_cnt == MW'(POLL_MS - 1)) begin ph <= PH_GAP; gap_cnt <= '0; end
          else ms_cnt <= ms_cnt + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R2
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);
  // R9
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bs_ready |-> (!spi_cs_n && !eng_active));
  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < PW'(POLL_MAX));
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R4
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (done && err_q != ERR_NONE));
  // R12
  empty_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bs_empty) |=> (done && error && !busy && spi_cs_n));
endmodule

// File: tb/sim_fpga_cfg_seq.sv
`timescale 1ns/1ps
module sim_fpga_cfg_seq;
  localparam int HALF = 2, CLKHZ = 100_000, PMS = 10, PMAX = 6;
  localparam int CYC_MS = CLKHZ / 1000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bs_empty = 1'b0;
  logic [7:0] bs_data = 8'h00;
  logic bs_valid = 1'b0, bs_last = 1'b0, spi_miso = 1'b0;
  logic bs_ready, spi_sclk, spi_mosi, spi_cs_n, busy, done, error;
  logic [2:0] err_code;

  always #5 clk = ~clk;

  fpga_cfg_seq #(.CLK_HZ(CLKHZ), .SCLK_HALF(HALF), .POLL_MS(PMS), .POLL_MAX(PMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bs_empty(bs_empty), .bs_data(bs_data),
    .bs_valid(bs_valid), .bs_last(bs_last), .bs_ready(bs_ready), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .busy(busy),
    .done(done), .error(error), .err_code(err_code));

  int ntot = 0, nbad = 0;
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------- SPI slave model ----------
  logic [31:0] id_val = 0, clr_word = 0, fin_stat = 0;
  int clr_after = 0;
  logic [7:0] fb [0:63][0:31];
  int flen [0:63];
  int fstart [0:63];
  int nfr = 0, cur = 0, bitcnt = 0, cyc = 0, cs_hi = 0, min_gap = 1000000;
  int stat_reads = 0;
  bit clear_seen = 0, wdis_seen = 0, prev_cs = 1, prev_sclk = 0;
  logic [7:0] sh = 0;

  function automatic logic [31:0] resp(logic [7:0] op);
    if (op == 8'h07) return id_val;
    if (op != 8'h09) return 32'h0;
    if (wdis_seen) return fin_stat;
    if (clear_seen) return (stat_reads < clr_after) ? 32'h0 : clr_word;
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !spi_cs_n) begin
      cur = nfr % 64; nfr++; bitcnt = 0; fstart[cur] = cyc;
      if (cs_hi < min_gap) min_gap = cs_hi;
    end
    if (spi_cs_n) cs_hi++; else cs_hi = 0;
    if (!spi_cs_n) begin
      if (!prev_sclk && spi_sclk) begin
        sh = {sh[6:0], spi_mosi};
        if (bitcnt % 8 == 7 && bitcnt / 8 < 32) fb[cur][bitcnt / 8] = sh;
      end
      if (prev_sclk && !spi_sclk) bitcnt++;
    end
    if (!prev_cs && spi_cs_n) begin
      flen[cur] = bitcnt / 8;
      case (fb[cur][0])
        8'h07: begin clear_seen = 0; wdis_seen = 0; stat_reads = 0; end
        8'h70: clear_seen = 1;
        8'h4F: wdis_seen = 1;
        8'h09: if (clear_seen && !wdis_seen) stat_reads++;
        default: ;
      endcase
    end
    if (!spi_cs_n && bitcnt >= 32 && bitcnt < 64) begin
      logic [31:0] w;
      w = resp(fb[cur][0]);
      spi_miso = w[31 - (bitcnt - 32)];
    end else spi_miso = 1'b0;
    prev_cs = spi_cs_n; prev_sclk = spi_sclk;
  end

  // ---------- bitstream source ----------
  logic [7:0] pay [0:15];
  int plen = 0, pidx = 0;
  bit stall = 0, feed_rst = 0, took = 0;
  always @(posedge clk) took <= bs_valid && bs_ready;
  always @(negedge clk) begin
    if (feed_rst) pidx = 0;
    else if (took) pidx++;
    bs_valid = (pidx < plen) && !(stall && (cyc % 3 == 0));
    bs_data  = (pidx < plen) ? pay[pidx] : 8'h00;
    bs_last  = (pidx == plen - 1);
  end

  // ---------- helpers ----------
  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(string req);
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk(req, 0, 1, "run finished (watchdog)");
  endtask

  task automatic setup(logic [31:0] id, int ca, logic [31:0] cw, logic [31:0] fs, int n, bit st);
    id_val = id; clr_after = ca; clr_word = cw; fin_stat = fs; stall = st; plen = n;
    for (int i = 0; i < n; i++) pay[i] = 8'h30 + 8'(i * 7);
    @(negedge clk); feed_rst = 1; @(negedge clk); feed_rst = 0;
  endtask

  task automatic chk_cmd(string req, int f, logic [7:0] op, int len);
    chk(req, fb[f % 64][0], op, "opcode");
    chk(req, flen[f % 64], len, "frame length");
    chk(req, fb[f % 64][len - 1], 8'h00, "stuffing byte");
  endtask

  // ---------- scenarios ----------
  task automatic t_reset();
    chk("R1", spi_cs_n, 1, "cs_n after reset");
    chk("R1", spi_sclk, 0, "sclk after reset");
    chk("R1", {busy, done, error}, 0, "busy/done/error after reset");
  endtask

  task automatic t_empty();
    int base = nfr;
    bs_empty = 1'b1; pulse_start(); @(negedge clk);
    chk("R12", {done, error}, 2'b11, "empty run flags");
    chk("R12", err_code, 1, "empty code");
    chk("R12", nfr - base, 0, "no frames for empty");
    bs_empty = 1'b0;
  endtask

  task automatic t_badid();
    int base = nfr;
    setup(32'h1234_5678, 0, 32'h0001_0000, 32'h4000, 3, 0);
    pulse_start(); wait_done("R4"); repeat (20) @(negedge clk);
    chk("R4", err_code, 2, "unsupported code");
    chk("R4", nfr - base, 1, "frames after bad id");
    chk_cmd("R3", base, 8'h07, 8);
    chk("R3", fb[base % 64][3], 8'h00, "id stuffing");
  endtask

  task automatic t_ok();
    int base = nfr, b;
    setup(32'hC208_8080, 2, 32'h0001_0000, 32'h0000_4000, 5, 1);
    pulse_start();
    repeat (400) @(negedge clk);
    chk("R13", busy, 1, "busy mid run");
    pulse_start();
    wait_done("R11"); repeat (20) @(negedge clk);
    chk("R11", {done, error}, 2'b10, "success flags");
    chk("R13", nfr - base, 11, "frame count with extra start");
    chk_cmd("R5", base + 1, 8'h09, 8);
    chk_cmd("R5", base + 2, 8'h71, 4);
    chk_cmd("R5", base + 3, 8'h4A, 4);
    chk_cmd("R5", base + 4, 8'h70, 4);
    for (int k = 5; k < 8; k++) chk_cmd("R6", base + k, 8'h09, 8);
    chk("R7", (fstart[(base + 6) % 64] - fstart[(base + 5) % 64]) >= PMS * CYC_MS, 1, "poll spacing");
    b = (base + 8) % 64;
    chk("R8", flen[b], 13, "burst length");
    chk("R8", {fb[b][0], fb[b][1], fb[b][2], fb[b][3]}, 32'h41FF_FFFF, "burst header");
    for (int i = 0; i < 5; i++) chk("R9", fb[b][4 + i], pay[i], "payload byte");
    chk("R8", {fb[b][9], fb[b][10], fb[b][11], fb[b][12]}, 32'h0, "burst trailer");
    chk_cmd("R10", base + 9, 8'h4F, 4);
    chk_cmd("R10", base + 10, 8'h09, 8);
  endtask

  task automatic t_timeout();
    int base = nfr, polls = 0;
    setup(32'hC204_8080, 0, 32'h0001_0001, 32'h4000, 2, 0);
    pulse_start(); wait_done("R7"); repeat (20) @(negedge clk);
    chk("R7", err_code, 3, "timeout code");
    chk("R6", nfr - base, 5 + PMAX, "frames on near-miss word");
    for (int k = 5; k < nfr - base; k++) if (fb[(base + k) % 64][0] == 8'h09) polls++;
    chk("R7", polls, PMAX, "poll count");
    chk("R7", fb[(nfr - 1) % 64][0] == 8'h41, 0, "no burst after timeout");
  endtask

  task automatic t_notcfg();
    int base = nfr;
    setup(32'hC208_8080, 0, 32'h0001_0000, 32'hFFFF_BFFF, 1, 0);
    pulse_start(); wait_done("R11"); repeat (20) @(negedge clk);
    chk("R11", {done, error}, 2'b11, "not configured flags");
    chk("R11", err_code, 4, "not configured code");
    chk("R8", flen[(base + 6) % 64], 9, "one-byte burst length");
    chk("R8", fb[(base + 6) % 64][4], pay[0], "one-byte payload");
    chk("R2", min_gap >= 4 * HALF, 1, "chip-select gap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_empty();
    t_badid();
    t_ok();
    t_timeout();
    t_notcfg();
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    #1_900_000;
    ntot++; nbad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule